// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block holds a bank of byte-addressed counter storage, 2048 bytes by default. Each location can be updated atomically with respect to every other request. A single request port accepts two kinds of operation. A load names a location, an access size, a signed increment of up to 22 bits and an optional tag-wait flag, all packed into its address. It returns the value the location held before the operation, sign-extended to 64 bits, and writes back the old value plus the increment. A store names a location and a size and carries 64 bits of write data. One address bit chooses whether that data is added to the location or replaces it.

A tag-wait load does not touch storage until the external `tag_done` input is seen high. If `tag_done` does not arrive within a parameterised number of cycles, the load gives up. It returns an error response and the location is left as it was. A load whose offset is not aligned to its size is also rejected with an error. A misaligned store is dropped without any response. Only one read-modify-write is in flight at a time, so any sequence of operations behaves as if each one ran alone and in order.

Top module: `fadd_bank`

## Requirements
- R1: The offset is a byte offset taken from `req_addr[10:0]`. Accesses of 2, 4 and 8 bytes must be aligned to their size. A load with a misaligned offset gets a response with `rsp_err`=1 and `rsp_data`=0x8000_0000_0000_0000, and storage does not change.
- R2: `req_size` selects the access width: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes and 3 gives 8 bytes.
- R3: On a load (`req_store`=0), `req_addr[35:14]` is a two's-complement increment. It is sign-extended before the add, so negative increments subtract.
- R4: A load returns the prior value of the addressed field, sign-extended to 64 bits, with `rsp_err`=0. The field then becomes the prior value plus the increment, wrapping modulo the field width.
- R5: On a store (`req_store`=1), `req_addr[13]`=0 adds `req_wdata` to the field, wrapping modulo the field width. `req_addr[13]`=1 overwrites the field with the low bytes of `req_wdata`. A store gives no response, and a misaligned store changes nothing.
- R6: Fields are stored in little-endian order: byte offset N+i holds bits 8i+7:8i. No byte outside the addressed field ever changes.
- R7: A load with `req_addr[13]`=1 waits until `tag_done` is sampled high, and then completes as a normal load.
- R8: If `tag_done` stays low for TMO_CYCLES cycles after a tag-wait load is accepted, the load ends with `rsp_err`=1 and `rsp_data`=0x8000_0000_0000_0000. The response is visible TMO_CYCLES+1 falling edges after the accepting edge, and storage does not change.
- R9: `req_ready` is low while an accepted aligned operation is being processed, so only one is in flight. Back-to-back operations on one location each see the result of the one before.
- R10: After reset every byte of the bank is zero, `req_ready` is high and `rsp_valid` is low.
- R11: An aligned load without tag-wait responds one cycle after the edge that accepts it, with `rsp_valid` high after the second rising edge. A misaligned load responds right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted on an edge where both are high |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 36 | Offset [10:0], mode or tag-wait flag [13], load increment [35:14] |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Store data |
| tag_done | input | 1 | Tag-switch-complete indication for tag-wait loads |
| rsp_valid | output | 1 | One-cycle load response strobe |
| rsp_err | output | 1 | Response is an error (misaligned or timed out) |
| rsp_data | output | 64 | Prior value, sign-extended, or the error word |

## Verification
A corrupted byte in the bank, a wrong lane shift or a broken merge shows up at the latest on the next load of any field that covers that byte. The load's returned prior value then differs from the bench's byte-level model. A stuck controller state shows within a cycle or two: `req_ready` fails to drop after acceptance, the response latency moves off two cycles, or the timeout fires at the wrong count. Random traffic is kept to a small window of offsets so that fields of different sizes overlap, which exposes lane errors within a few operations.

// File: rtl/fadd_pkg.sv
package fadd_pkg;

    localparam int ADDR_W   = 36;
    localparam int DATA_W   = 64;
    localparam int OFF_W    = 11;
    localparam int FLAG_BIT = 13;
    localparam int INC_LSB  = 14;
    localparam int INC_W    = 22;

    localparam logic [DATA_W-1:0] ERR_WORD = {1'b1, {(DATA_W-1){1'b0}}};

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } state_e;

    typedef struct packed {
        logic              is_store;
        logic              overwrite;
        logic              tagwait;
        size_e             size;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] operand;
    } op_t;

    function automatic logic [DATA_W-1:0] lane_mask(input size_e sz);
        case (sz)
            SZ_B:    return 64'h0000_0000_0000_00FF;
            SZ_H:    return 64'h0000_0000_0000_FFFF;
            SZ_W:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:0] byte_sel(input size_e sz, input logic [2:0] boff);
        logic [7:0] base;
        case (sz)
            SZ_B:    base = 8'h01;
            SZ_H:    base = 8'h03;
            SZ_W:    base = 8'h0F;
            default: base = 8'hFF;
        endcase
        return base << boff;
    endfunction

    function automatic logic is_aligned(input size_e sz, input logic [2:0] boff);
        case (sz)
            SZ_B:    return 1'b1;
            SZ_H:    return boff[0] == 1'b0;
            SZ_W:    return boff[1:0] == 2'b00;
            default: return boff == 3'b000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] sign_ext(input logic [DATA_W-1:0] v, input size_e sz);
        case (sz)
            SZ_B:    return {{56{v[7]}}, v[7:0]};
            SZ_H:    return {{48{v[15]}}, v[15:0]};
            SZ_W:    return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/fadd_decode.sv
module fadd_decode
    import fadd_pkg::*;
(
    input  logic              is_store,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output op_t               op,
    output logic              aligned
);
    logic [DATA_W-1:0] inc_ext;

    assign inc_ext = {{(DATA_W-INC_W){addr[INC_LSB+INC_W-1]}}, addr[INC_LSB +: INC_W]};

    always_comb begin
        op.is_store  = is_store;
        op.size      = size_e'(size);
        op.off       = addr[OFF_W-1:0];
        op.overwrite = is_store & addr[FLAG_BIT];
        op.tagwait   = ~is_store & addr[FLAG_BIT];
        op.operand   = is_store ? wdata : inc_ext;
    end

    assign aligned = is_aligned(size_e'(size), addr[2:0]);

endmodule

// File: rtl/fadd_lane.sv
module fadd_lane
    import fadd_pkg::*;
(
    input  op_t               op,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] word_out,
    output logic [DATA_W-1:0] prior
);
    localparam int NBYTES = DATA_W / 8;

    logic [5:0]        sh;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] old_lane;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] new_shifted;
    logic [NBYTES-1:0] be;

    assign sh          = {op.off[2:0], 3'b000};
    assign mask        = lane_mask(op.size);
    assign old_lane    = (word_in >> sh) & mask;
    assign sum         = op.overwrite ? op.operand : (old_lane + op.operand);
    assign new_shifted = (sum & mask) << sh;
    assign be          = byte_sel(op.size, op.off[2:0]);
    assign prior       = sign_ext(old_lane, op.size);

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign word_out[8*b +: 8] = be[b] ? new_shifted[8*b +: 8] : word_in[8*b +: 8];
    end

endmodule

// File: rtl/fadd_words.sv
module fadd_words
    import fadd_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] rd_word,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_word
);
    logic [DATA_W-1:0] mem [WORDS];

    assign rd_word = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[idx] <= wr_word;
        end
    end

endmodule

// File: rtl/fadd_ctrl.sv
module fadd_ctrl
    import fadd_pkg::*;
#(
    parameter int TMO_CYCLES = 16,
    localparam int CNT_W = $clog2(TMO_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  op_t               dec_op,
    input  logic              dec_aligned,
    input  logic              tag_done,
    input  logic [DATA_W-1:0] exec_prior,
    output logic              req_ready,
    output op_t               cur_op,
    output logic              mem_we,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

    state_e           state;
    logic [CNT_W-1:0] wait_cnt;

    assign req_ready = (state == ST_IDLE);
    assign mem_we    = (state == ST_EXEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            wait_cnt  <= '0;
            cur_op    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!dec_aligned) begin
                            if (!dec_op.is_store) begin
                                rsp_valid <= 1'b1;
                                rsp_err   <= 1'b1;
                                rsp_data  <= ERR_WORD;
                            end
                        end else begin
                            cur_op   <= dec_op;
                            wait_cnt <= '0;
                            state    <= dec_op.tagwait ? ST_WAIT : ST_EXEC;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tag_done) begin
                        state <= ST_EXEC;
                    end else if (wait_cnt == CNT_LAST) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_data  <= ERR_WORD;
                        state     <= ST_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_EXEC: begin
                    if (!cur_op.is_store) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= exec_prior;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    tmo_window_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (wait_cnt < CNT_W'(TMO_CYCLES)));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !tag_done && wait_cnt != CNT_LAST) |=> (state == ST_WAIT && !rsp_valid));

    // R9
    exec_release_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> req_ready);

endmodule

// File: rtl/fadd_bank.sv
module fadd_bank
    import fadd_pkg::*;
#(
    parameter int BANK_BYTES = 2048,
    parameter int TMO_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [35:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    input  logic              tag_done,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_data
);
    localparam int WORDS = BANK_BYTES / 8;
    localparam int IDX_W = $clog2(WORDS);

    op_t               dec_op;
    logic              dec_aligned;
    op_t               cur_op;
    logic              mem_we;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] prior;
    logic [IDX_W-1:0]  idx;
    logic              accept;

    assign idx    = cur_op.off[IDX_W+2:3];
    assign accept = req_valid && req_ready;

    fadd_decode u_decode (
        .is_store (req_store),
        .addr     (req_addr),
        .size     (req_size),
        .wdata    (req_wdata),
        .op       (dec_op),
        .aligned  (dec_aligned)
    );

    fadd_ctrl #(.TMO_CYCLES(TMO_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .dec_op      (dec_op),
        .dec_aligned (dec_aligned),
        .tag_done    (tag_done),
        .exec_prior  (prior),
        .req_ready   (req_ready),
        .cur_op      (cur_op),
        .mem_we      (mem_we),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_data    (rsp_data)
    );

    fadd_words #(.WORDS(WORDS)) u_words (
        .clk     (clk),
        .rst     (rst),
        .idx     (idx),
        .rd_word (rd_word),
        .we      (mem_we),
        .wr_word (wr_word)
    );

    fadd_lane u_lane (
        .op       (cur_op),
        .word_in  (rd_word),
        .word_out (wr_word),
        .prior    (prior)
    );

    // R11
    plain_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_aligned && !req_store && !req_addr[FLAG_BIT])
        |=> !rsp_valid ##1 (rsp_valid && !rsp_err));

    // R1
    misalign_load_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec_aligned && !req_store) |=> (rsp_valid && rsp_err && req_ready));

    // R5
    misalign_store_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec_aligned && req_store) |=> (req_ready && !rsp_valid));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_aligned) |=> !req_ready);

endmodule

// File: tb/test_fadd_bank.sv
module test_fadd_bank;
    localparam int TMO = 16;
    localparam logic [63:0] ERRW = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [35:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        tag_done = 1'b0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0]  ref_mem [2048];
    logic [63:0] last_data;
    logic        last_err;

    always #10 clk = ~clk;

    fadd_bank #(.BANK_BYTES(2048), .TMO_CYCLES(TMO)) i_fadd_bank (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_store (req_store),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .tag_done  (tag_done),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_data  (rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sx(input logic [63:0] v, input int sz);
        case (sz)
            0:       return {{56{v[7]}}, v[7:0]};
            1:       return {{48{v[15]}}, v[15:0]};
            2:       return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] ref_get(input int off, input int sz);
        logic [63:0] v = '0;
        for (int i = 0; i < (1 << sz); i++) begin
            v = v | (64'(ref_mem[off + i]) << (8 * i));
        end
        return sx(v, sz);
    endfunction

    task automatic ref_put(input int off, input int sz, input logic [63:0] v);
        for (int i = 0; i < (1 << sz); i++) begin
            ref_mem[off + i] = v[8*i +: 8];
        end
    endtask

    // st=1: flag is the overwrite mode, val is store data.
    // st=0: flag is tag-wait, val[21:0] is the increment; tdone=0 means never.
    task automatic run_op(input bit st, input bit flag, input int off, input int sz,
                          input logic [63:0] val, input int tdone, input string req);
        logic [35:0] a;
        logic [63:0] exp_old;
        logic [63:0] inc64;
        int lat;
        bit al;
        bit rdy1;
        al = ((off % (1 << sz)) == 0);
        a = '0;
        a[10:0] = off[10:0];
        a[13] = flag;
        if (!st) a[35:14] = val[21:0];
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_store = st;
        req_addr  = a;
        req_size  = sz[1:0];
        req_wdata = st ? val : 64'h0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat  = 1;
        rdy1 = req_ready;
        if (st) begin
            if (al) begin
                chk(!rdy1, "R9 busy after store", 64'(rdy1), 64'h0);
                exp_old = ref_get(off, sz);
                ref_put(off, sz, flag ? val : (exp_old + val));
            end else begin
                chk(rdy1 && !rsp_valid, "R5 misaligned store dropped", {rdy1, rsp_valid}, 2'b10);
            end
            return;
        end
        while (!rsp_valid && lat < TMO + 20) begin
            tag_done = (lat == tdone);
            @(negedge clk);
            lat++;
        end
        tag_done = 1'b0;
        last_err  = rsp_err;
        last_data = rsp_data;
        chk(rsp_valid, {req, " response present"}, 64'(rsp_valid), 64'h1);
        if (!al) begin
            chk(rsp_err && rsp_data == ERRW, "R1 misaligned load error", rsp_data, ERRW);
            chk(lat == 1, "R11 misaligned latency", 64'(lat), 64'd1);
        end else if (flag && tdone == 0) begin
            chk(rsp_err && rsp_data == ERRW, "R8 timeout error word", rsp_data, ERRW);
            chk(lat == TMO + 1, "R8 timeout latency", 64'(lat), 64'(TMO + 1));
        end else begin
            exp_old = ref_get(off, sz);
            inc64 = {{42{val[21]}}, val[21:0]};
            chk(!rsp_err && rsp_data == exp_old, {req, " prior value"}, rsp_data, exp_old);
            chk(!rdy1, "R9 busy after load", 64'(rdy1), 64'h0);
            if (!flag) chk(lat == 2, "R11 load latency", 64'(lat), 64'd2);
            ref_put(off, sz, exp_old + inc64);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 2048; i++) ref_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready && !rsp_valid, "R10 idle after reset", {req_ready, rsp_valid}, 2'b10);
        run_op(0, 0, 2040, 3, 64'h0, 0, "R10 zero contents");
        chk(last_data == 64'h0, "R10 zero value", last_data, 64'h0);

        // R5 overwrite, R6 lane order
        run_op(1, 1, 8, 3, 64'h1122_3344_5566_7788, 0, "R5");
        run_op(0, 0, 11, 0, 64'h1, 0, "R6 byte lane");
        chk(last_data == 64'h55, "R6 byte 11 value", last_data, 64'h55);
        run_op(0, 0, 8, 3, 64'h0, 0, "R6 word");
        chk(last_data == 64'h1122_3344_5666_7788, "R6 neighbours intact", last_data, 64'h1122_3344_5666_7788);

        // R4 wrap and sign extension, R2 byte size
        run_op(1, 1, 16, 0, 64'h7F, 0, "R5");
        run_op(0, 0, 16, 0, 64'h1, 0, "R2 byte");
        chk(last_data == 64'h7F, "R4 prior 0x7f", last_data, 64'h7F);
        run_op(0, 0, 16, 0, 64'h0, 0, "R4");
        chk(last_data == 64'hFFFF_FFFF_FFFF_FF80, "R4 wrapped and sign-extended", last_data, 64'hFFFF_FFFF_FFFF_FF80);

        // R3 negative increment, R2 word size
        run_op(1, 1, 24, 2, 64'h5, 0, "R5");
        run_op(0, 0, 24, 2, 64'h3F_FFF9, 0, "R3 minus seven");
        chk(last_data == 64'h5, "R3 prior", last_data, 64'h5);
        run_op(0, 0, 24, 2, 64'h0, 0, "R2 word");
        chk(last_data == 64'hFFFF_FFFF_FFFF_FFFE, "R3 result -2", last_data, 64'hFFFF_FFFF_FFFF_FFFE);

        // R5 store add wraps in a halfword
        run_op(1, 1, 32, 1, 64'hFFFF, 0, "R5");
        run_op(1, 0, 32, 1, 64'h2, 0, "R5");
        run_op(0, 0, 32, 1, 64'h0, 0, "R5 store add");
        chk(last_data == 64'h1, "R5 added halfword", last_data, 64'h1);

        // R1 misaligned load, then storage unchanged
        run_op(0, 0, 26, 2, 64'h10, 0, "R1");
        run_op(0, 0, 24, 2, 64'h0, 0, "R1 no update");
        // R5 misaligned store dropped
        run_op(1, 1, 12, 3, 64'hDEAD_BEEF_0000_0000, 0, "R5");
        run_op(0, 0, 8, 3, 64'h0, 0, "R5 dropped store");

        // R7 tag wait then complete
        run_op(0, 1, 40, 3, 64'h9, 3, "R7 tag wait");
        run_op(0, 0, 40, 3, 64'h0, 0, "R7 update applied");
        chk(last_data == 64'h9, "R7 value", last_data, 64'h9);

        // R8 timeout leaves storage alone
        run_op(0, 1, 40, 3, 64'h100, 0, "R8");
        run_op(0, 0, 40, 3, 64'h0, 0, "R8 no update");
        chk(last_data == 64'h9, "R8 value kept", last_data, 64'h9);

        // R9 back-to-back on one location
        for (int k = 0; k < 4; k++) run_op(0, 0, 48, 2, 64'h3, 0, "R9 back-to-back");
        chk(last_data == 64'h9, "R9 accumulated", last_data, 64'h9);

        // Random mixed traffic over overlapping fields
        for (int n = 0; n < 400; n++) begin
            bit st;
            bit fl;
            int sz;
            int off;
            int td;
            logic [63:0] v;
            st  = ($urandom % 3) == 0;
            sz  = $urandom % 4;
            off = $urandom % 64;
            if (($urandom % 8) != 0) off = off & ~((1 << sz) - 1);
            fl  = st ? 1'($urandom % 2) : (($urandom % 6) == 0);
            td  = (!st && fl) ? 1 + ($urandom % 5) : 0;
            v   = {$urandom, $urandom};
            run_op(st, fl, off, sz, v, td, st ? "R5 random" : "R4 random");
        end
        for (int off = 0; off < 64; off += 8) run_op(0, 0, off, 3, 64'h0, 0, "R6 final sweep");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule